// File: doc/BRIEF.md
# Cascadable Serial-In Latched LED Sink Driver

This block takes a serial bit stream and turns it into sixteen pull-low pad controls for a row of common-anode LEDs. Bits enter on the rising edge of a shift strobe into a sixteen-stage chain. A separate rising edge on a latch strobe copies the whole chain into a holding register, and that register drives the pads. Every stage holds the complement of the bit that entered it, so a high serial bit lights its LED. Each pad is presented as a drive enable plus a drive value that is always low. A released pad floats and is pulled high off-chip. A push-pull cascade output repeats the serial stream sixteen shifts late, so several devices can be chained to drive longer rows.

The shift and latch strobes and the serial data are levels sampled by the block's system clock. They pass through a synchronizer and an edge detector, so one strobe edge causes one register update a fixed number of cycles later. An active-low reset forces both register stages to all ones at once, which turns every LED off. Its release is synchronized, so no strobe edge is taken until the chip's logic is out of reset. An active-high disable releases all pads at once and leaves the registers running.

Top module: `serial_sink_driver`

## Requirements
- R1: Each rising edge of `shift_clk` moves the chain one stage toward the last stage. The first stage stores the complement of the `ser_in` level that was present with the edge. A level that is held high, with no low-to-high change, causes no further shift.
- R2: `cascade_out` is the complement of the last chain stage. It therefore repeats the `ser_in` bit that was shifted in sixteen shifts earlier, and it is low when fewer than sixteen shifts have happened since reset. It stays driven while `out_disable` is high, and a second device fed from it receives the first device's stream unchanged.
- R3: The holding register changes only on a rising edge of `latch_clk`. It then takes the whole chain at once. Shifting without a latch edge leaves every `sink_en` bit unchanged.
- R4: `sink_en[i]` is 1 (pull the pad low, LED lit) exactly when held bit i is 0 and `out_disable` is low. `sink_val` is always all zeros. If a 16-bit word is shifted most-significant bit first and then latched, `sink_en` equals that word.
- R5: While `rst_n` is low, both stages are all ones without waiting for a clock. `sink_en` is then all zeros, `cascade_out` is 0, and strobe edges have no effect.
- R6: While `out_disable` is high, every `sink_en` bit is 0 regardless of the held data. Shifting and latching still go on, so the data latched during the disable appears as soon as the disable falls.
- R7: Release of `rst_n` is synchronized. If a strobe level is already high when reset is released, that is not taken as an edge. The first shift after reset is the first true low-to-high change of `shift_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized release |
| ser_in | input | 1 | Serial data; a high level lights the LED |
| shift_clk | input | 1 | Shift strobe, acts on its rising edge |
| latch_clk | input | 1 | Latch strobe, acts on its rising edge |
| out_disable | input | 1 | High releases all sixteen pads |
| sink_en | output | WIDTH | Per-pad drive enable, 1 pulls the pad low |
| sink_val | output | WIDTH | Per-pad drive value, always 0 |
| cascade_out | output | 1 | Driven serial output toward the next device |

## Verification
The hardest case to reach is a reset release while a strobe is already held high. A design that misses it sees a false edge, and nothing shows at the pads until sixteen shifts later. The bench holds `shift_clk` and `ser_in` high across the whole reset and its release, then lowers the strobe. It shifts fifteen and then sixteen zeros and checks that `cascade_out` stays low, because a phantom shift would have pushed a lit bit out after exactly fifteen. The chained case is reached by feeding a second instance from the first one's cascade output and shifting thirty-two bits before a single latch.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    // One sample of the asynchronous strobe and data levels.
    typedef struct packed {
        logic shift_lvl;
        logic latch_lvl;
        logic dat;
    } ssd_sample_t;

endpackage

// File: rtl/ssd_rst_sync.sv
module ssd_rst_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic run
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.chain[STAGES-1];

    // R7: the run flag never rises in the first cycle after reset release
    p_late_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(st_q.chain[STAGES-2]));
endmodule

// File: rtl/ssd_input_sync.sv
module ssd_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic shift_lvl,
    input  logic latch_lvl,
    input  logic dat_in,
    output logic shift_stb,
    output logic latch_stb,
    output logic dat_out
);
    import ssd_pkg::*;

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        ssd_sample_t [STAGES-1:0] pipe;
        logic                     shift_prev;
        logic                     latch_prev;
    } is_state_t;

    is_state_t st_d, st_q;

    always_comb begin
        st_d                   = st_q;
        st_d.pipe[0].shift_lvl = shift_lvl;
        st_d.pipe[0].latch_lvl = latch_lvl;
        st_d.pipe[0].dat       = dat_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.shift_prev = st_q.pipe[LAST].shift_lvl;
        st_d.latch_prev = st_q.pipe[LAST].latch_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_stb = run & st_q.pipe[LAST].shift_lvl & ~st_q.shift_prev;
    assign latch_stb = run & st_q.pipe[LAST].latch_lvl & ~st_q.latch_prev;
    assign dat_out   = st_q.pipe[LAST].dat;

    // R1: one strobe edge produces a single-cycle step
    p_one_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> !shift_stb);
    // R3: one latch edge produces a single-cycle load
    p_one_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);
endmodule

// File: rtl/ssd_shift_chain.sv
module ssd_shift_chain #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             din,
    output logic [WIDTH-1:0] bits
);
    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } sc_state_t;

    sc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.stage = {st_q.stage[WIDTH-2:0], ~din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign bits = st_q.stage;

    // R1: a step moves every stage up one place and inverts the new bit
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (bits == {$past(bits[WIDTH-2:0]), ~$past(din)}));
    // R1: with no step the chain holds
    p_hold_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(bits));
endmodule

// File: rtl/ssd_hold.sv
module ssd_hold #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] held
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hd_state_t;

    hd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign held = st_q.word;

    // R3: without a load the held word does not move
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held));
    // R3: a load captures the chain as it stood
    p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (held == $past(src)));
endmodule

// File: rtl/serial_sink_driver.sv
module serial_sink_driver #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             latch_clk,
    input  logic             out_disable,
    output logic [WIDTH-1:0] sink_en,
    output logic [WIDTH-1:0] sink_val,
    output logic             cascade_out
);
    // The reset chain is one longer than the strobe path, so the strobe
    // path is full before any edge can be taken.
    localparam int RST_STAGES = SYNC_STAGES + 1;

    logic             run;
    logic             shift_stb;
    logic             latch_stb;
    logic             dat_s;
    logic [WIDTH-1:0] chain_bits;
    logic [WIDTH-1:0] held_bits;

    ssd_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    ssd_input_sync #(.STAGES(SYNC_STAGES)) i_input_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .shift_lvl (shift_clk),
        .latch_lvl (latch_clk),
        .dat_in    (ser_in),
        .shift_stb (shift_stb),
        .latch_stb (latch_stb),
        .dat_out   (dat_s)
    );

    ssd_shift_chain #(.WIDTH(WIDTH)) i_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (shift_stb),
        .din   (dat_s),
        .bits  (chain_bits)
    );

    ssd_hold #(.WIDTH(WIDTH)) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_stb),
        .src   (chain_bits),
        .held  (held_bits)
    );

    // Pad control: pull low for a held 0, unless the pads are disabled.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sink_en[i]  = ~held_bits[i] & ~out_disable;
            sink_val[i] = 1'b0;
        end
    end

    assign cascade_out = ~chain_bits[WIDTH-1];

    // R2: after a step the cascade shows the inverse of the old next-to-last stage
    p_cascade_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |=> (cascade_out == ~$past(chain_bits[WIDTH-2])));
    // R5: reset leaves every pad released and the cascade low
    p_reset_r5: assert property (@(posedge clk)
        !rst_n |-> ((sink_en == '0) && !cascade_out));
    // R6: disable releases every pad
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> (sink_en == '0));
    // R7: no strobe is taken in the cycle reset leaves
    p_no_early_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!shift_stb && !latch_stb));
endmodule

// File: tb/test_serial_sink_driver.sv
module test_serial_sink_driver;
    localparam int W = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         shift_clk = 1'b0;
    logic         latch_clk = 1'b0;
    logic         out_disable = 1'b0;
    logic [W-1:0] sink_en, sink_val, en2, val2;
    logic         cascade_out, casc2;
    logic [W-1:0] pins;

    serial_sink_driver i_serial_sink_driver (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .latch_clk(latch_clk), .out_disable(out_disable),
        .sink_en(sink_en), .sink_val(sink_val), .cascade_out(cascade_out)
    );

    serial_sink_driver i_next (
        .clk(clk), .rst_n(rst_n), .ser_in(cascade_out), .shift_clk(shift_clk),
        .latch_clk(latch_clk), .out_disable(1'b0),
        .sink_en(en2), .sink_val(val2), .cascade_out(casc2)
    );

    // Pull-up model on every released pad.
    always_comb begin
        for (int i = 0; i < W; i++) pins[i] = sink_en[i] ? sink_val[i] : 1'b1;
    end

    int n_total = 0;
    int n_fail  = 0;
    logic [W-1:0] hist     = '0;  // serial bits, newest in bit 0
    logic [W-1:0] model_en = '0;  // enables latched by the model

    // {disable during load, word shifted MSB first}
    localparam logic [W:0] VEC [12] = '{
        17'h0_A5C3, 17'h0_FFFF, 17'h0_0000, 17'h1_8001,
        17'h0_1234, 17'h1_FFFF, 17'h0_5555, 17'h0_AAAA,
        17'h1_0F0F, 17'h0_F00F, 17'h0_0001, 17'h0_8000
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_en();
        return out_disable ? '0 : model_en;
    endfunction

    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        shift_clk = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
        hist = {hist[W-2:0], b};
    endtask

    task automatic shift_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) begin
            shift_bit(w[i]);
            chk("R3 pads steady while shifting", sink_en, exp_en());
            chk("R2 cascade delay", {{(W-1){1'b0}}, cascade_out}, {{(W-1){1'b0}}, hist[W-1]});
        end
    endtask

    task automatic do_latch();
        @(negedge clk);
        latch_clk = 1'b1;
        repeat (4) @(negedge clk);
        latch_clk = 1'b0;
        repeat (4) @(negedge clk);
        model_en = hist;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R5 async pads released", sink_en, '0);
        chk("R5 async cascade low", {{(W-1){1'b0}}, cascade_out}, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        hist = '0;
        model_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 reset pads", sink_en, '0);
        chk("R5 reset pins high", pins, '1);
        chk("R4 drive value low", sink_val, '0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // Table walk: shift, check, latch under the vector's disable, check.
        for (int v = 0; v < 12; v++) begin
            shift_word(VEC[v][W-1:0]);
            out_disable = VEC[v][W];
            #1;
            chk("R6 disable releases", sink_en, exp_en());
            do_latch();
            chk("R4 pads after latch", sink_en, exp_en());
            chk("R4 pins pulled", pins, ~exp_en());
            chk("R3 latched word", model_en, VEC[v][W-1:0]);
            out_disable = 1'b0;
            #1;
            chk("R6 data after disable", sink_en, VEC[v][W-1:0]);
        end

        // Mid-run asynchronous reset with lit pads; edges during reset ignored.
        do_latch();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R5 mid-run pads", sink_en, '0);
        chk("R5 mid-run cascade", {{(W-1){1'b0}}, cascade_out}, '0);
        ser_in = 1'b1;
        shift_clk = 1'b1;
        latch_clk = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk = 1'b0;
        latch_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 edges ignored in reset", sink_en, '0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        hist = '0;
        model_en = '0;

        // Disable with the cascade still driven.
        out_disable = 1'b1;
        shift_word(16'hC3A5);
        chk("R2 cascade driven while disabled", {{(W-1){1'b0}}, cascade_out}, {{(W-1){1'b0}}, 1'b1});
        do_latch();
        chk("R6 latched while disabled", sink_en, '0);
        out_disable = 1'b0;
        #1;
        chk("R6 latch took effect", sink_en, 16'hC3A5);

        // Strobe held high across reset release: no phantom shift.
        @(negedge clk);
        rst_n = 1'b0;
        ser_in = 1'b1;
        shift_clk = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        shift_clk = 1'b0;
        repeat (4) @(negedge clk);
        hist = '0;
        model_en = '0;
        for (int k = 0; k < W - 1; k++) shift_bit(1'b0);
        chk("R7 no phantom shift after 15", {{(W-1){1'b0}}, cascade_out}, '0);
        shift_bit(1'b0);
        chk("R7 no phantom shift after 16", {{(W-1){1'b0}}, cascade_out}, '0);
        chk("R1 held level gave no extra shift", sink_en, '0);

        // Two-device chain.
        do_reset();
        shift_word(16'h9E37);
        shift_word(16'h42B1);
        do_latch();
        chk("R2 chained far device", en2, 16'h9E37);
        chk("R1 near device", sink_en, 16'h42B1);
        chk("R2 far cascade", {{(W-1){1'b0}}, casc2}, {{(W-1){1'b0}}, 1'b1});
        chk("R4 far drive value", val2, '0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule